// File: doc/BRIEF.md
# Two-Step Integration Pixel Sequencer

This block runs one readout frame for a pixel that carries two input amplifiers: a low-flux path with a switchable feedback capacitor, and a high-flux follower path. Each frame starts with a short detection window. In that window the low-flux amplifier runs open loop as a comparator. If its comparator output is seen high at any sampled edge of the window, the high-flux path is chosen for the main integration. Otherwise the low-flux path stays selected and its feedback capacitor is switched in. After the main integration, the block holds the chosen path through an output phase, then drives the node reset switch for a reset phase, and then returns to idle.

The four phase lengths are cycle counts held in write-only registers. A short write port loads them. A single-cycle request starts a frame. A one-bit flag reports which path the frame used, for correction done downstream. A one-cycle done pulse marks the end of the output phase.

Top module: `dual_path_frame_seq`

## Requirements
- R1: A synchronous active-high reset returns the block to idle. It drives every switch output, `fb_cap_en`, `path_flag` and `done` low, and it reloads the phase counts with the parameter defaults (detect 4, main 8, output 2, reset 2).
- R2: A frame starts when `frame_go` is sampled high in idle. From the next cycle on, the block runs detect, then main, then output, then reset, and then returns to idle. Each phase lasts the number of cycles held in its register. The register addresses are 0 for detect, 1 for main, 2 for output and 3 for reset, written with `cfg_we`.
- R3: A programmed count of zero gives a phase that lasts exactly one cycle.
- R4: During detect, `sw_lo` is high, and `sw_hi` and `fb_cap_en` are low.
- R5: If `cmp_hit` is sampled high at any clock edge that ends a detect cycle, including the last one, the main and output phases run with `sw_hi` high and with `sw_lo` and `fb_cap_en` low.
- R6: If `cmp_hit` is never sampled high during detect, the main and output phases run with `sw_lo` and `fb_cap_en` high and with `sw_hi` low.
- R7: During main and output, exactly one of `sw_hi` and `sw_lo` is high, and the choice does not change until the reset phase.
- R8: `sw_rst` is high in every reset-phase cycle and in no other cycle. In idle, all switch outputs are low.
- R9: `path_flag` reads 0 from the first detect cycle through the last main cycle. From the first output cycle until the next frame start, it holds the path choice (0 = low-flux, 1 = high-flux).
- R10: `done` is high for exactly one cycle, the first cycle of the reset phase.
- R11: `frame_go` has no effect while a frame runs. `cmp_hit` has no effect outside the detect cycles, including in the idle cycle in which the frame is requested.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_we | input | 1 | Write strobe for a phase count |
| cfg_addr | input | 2 | Phase count select (0 detect, 1 main, 2 output, 3 reset) |
| cfg_wdata | input | 16 | Phase count in cycles |
| frame_go | input | 1 | Frame start request, used only in idle |
| cmp_hit | input | 1 | Synchronous comparator result, threshold exceeded |
| sw_hi | output | 1 | High-flux path switch enable |
| sw_lo | output | 1 | Low-flux path switch enable |
| fb_cap_en | output | 1 | Low-flux feedback capacitor enable |
| sw_rst | output | 1 | Node reset switch enable |
| path_flag | output | 1 | Path used by the last frame (1 = high-flux) |
| done | output | 1 | One-cycle pulse at the end of the output phase |

## Verification
The bench places a comparator hit in the first, middle and last detect cycles. A design that samples one cycle late or early would miss the last-cycle hit, or would accept a hit in the idle request cycle or in the first main cycle. It also runs frames with all counts at zero. A counter that does not clamp zero would wrap to a 65536-cycle phase. Start requests are injected mid-frame. A design that restarts on them would cut the frame short. The bench checks the flag from the first detect cycle through idle and checks `done` on every cycle, so a flag that updates at the wrong time or a done pulse that is stretched or early is caught. A reset issued mid-frame must return the block to idle and to the default phase counts.

// File: rtl/dps_pkg.sv
package dps_pkg;

  typedef enum logic [2:0] {
    PH_IDLE = 3'd0,
    PH_DET  = 3'd1,
    PH_MAIN = 3'd2,
    PH_OUT  = 3'd3,
    PH_RST  = 3'd4
  } phase_e;

  localparam int unsigned NUM_DUR = 4;
  localparam int unsigned DUR_DET  = 0;
  localparam int unsigned DUR_MAIN = 1;
  localparam int unsigned DUR_OUT  = 2;
  localparam int unsigned DUR_RST  = 3;

  typedef struct packed {
    logic hi;
    logic lo;
    logic fb;
    logic nrst;
  } sw_t;

endpackage

// File: rtl/dps_cfg_regs.sv
module dps_cfg_regs #(
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned NUM    = 4,
  parameter int unsigned ADDR_W = 2,
  parameter logic [NUM*CNT_W-1:0] DEFAULTS = '0
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 we,
  input  logic [ADDR_W-1:0]    addr,
  input  logic [CNT_W-1:0]     wdata,
  output logic [NUM*CNT_W-1:0] dur_flat
);

  for (genvar g = 0; g < NUM; g++) begin : g_reg
    logic [CNT_W-1:0] val_q;
    always_ff @(posedge clk) begin
      if (rst) begin
        val_q <= DEFAULTS[g*CNT_W +: CNT_W];
      end else if (we && (addr == ADDR_W'(g))) begin
        val_q <= wdata;
      end
    end
    assign dur_flat[g*CNT_W +: CNT_W] = val_q;
  end

endmodule

// File: rtl/dps_phase_timer.sv
module dps_phase_timer #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] count,
  output logic             last
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] start_val;

  // a count of zero runs the phase for a single cycle, same as one
  assign start_val = (count == '0) ? '0 : count - CNT_W'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= start_val;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - CNT_W'(1);
    end
  end

  assign last = (cnt_q == '0);

endmodule

// File: rtl/dps_path_select.sv
module dps_path_select (
  input  logic clk,
  input  logic rst,
  input  logic clear,
  input  logic det_active,
  input  logic commit,
  input  logic cmp_hit,
  output logic sel_q,
  output logic sel_d
);

  logic hit_q;

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      hit_q <= 1'b0;
    end else if (det_active && cmp_hit) begin
      hit_q <= 1'b1;
    end
  end

  always_comb begin
    sel_d = sel_q;
    if (clear) begin
      sel_d = 1'b0;
    end else if (commit) begin
      sel_d = hit_q | cmp_hit;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q <= 1'b0;
    end else begin
      sel_q <= sel_d;
    end
  end

endmodule

// File: rtl/dual_path_frame_seq.sv
module dual_path_frame_seq #(
  parameter int unsigned CNT_W    = 16,
  parameter int unsigned DET_DEF  = 4,
  parameter int unsigned MAIN_DEF = 8,
  parameter int unsigned OUT_DEF  = 2,
  parameter int unsigned RST_DEF  = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_we,
  input  logic [1:0]       cfg_addr,
  input  logic [CNT_W-1:0] cfg_wdata,
  input  logic             frame_go,
  input  logic             cmp_hit,
  output logic             sw_hi,
  output logic             sw_lo,
  output logic             fb_cap_en,
  output logic             sw_rst,
  output logic             path_flag,
  output logic             done
);
  import dps_pkg::*;

  localparam int unsigned ADDR_W = $clog2(NUM_DUR);
  localparam logic [NUM_DUR*CNT_W-1:0] DEFAULTS =
    {CNT_W'(RST_DEF), CNT_W'(OUT_DEF), CNT_W'(MAIN_DEF), CNT_W'(DET_DEF)};

  logic [NUM_DUR*CNT_W-1:0] dur_flat;
  logic [CNT_W-1:0]         dur [NUM_DUR];
  phase_e                   phase_q, phase_d;
  logic                     last, start, adv, load;
  logic [CNT_W-1:0]         load_val;
  logic                     sel_q, sel_d;
  sw_t                      sw_d, sw_q;
  logic                     flag_q, done_q;

  dps_cfg_regs #(
    .CNT_W(CNT_W), .NUM(NUM_DUR), .ADDR_W(ADDR_W), .DEFAULTS(DEFAULTS)
  ) u_cfg (
    .clk(clk), .rst(rst), .we(cfg_we), .addr(cfg_addr),
    .wdata(cfg_wdata), .dur_flat(dur_flat)
  );

  for (genvar g = 0; g < NUM_DUR; g++) begin : g_dur
    assign dur[g] = dur_flat[g*CNT_W +: CNT_W];
  end

  assign start = (phase_q == PH_IDLE) && frame_go;
  assign adv   = (phase_q != PH_IDLE) && last;

  always_comb begin
    phase_d = phase_q;
    unique case (phase_q)
      PH_IDLE: if (frame_go) phase_d = PH_DET;
      PH_DET:  if (last)     phase_d = PH_MAIN;
      PH_MAIN: if (last)     phase_d = PH_OUT;
      PH_OUT:  if (last)     phase_d = PH_RST;
      PH_RST:  if (last)     phase_d = PH_IDLE;
      default:               phase_d = PH_IDLE;
    endcase
  end

  always_comb begin
    unique case (phase_d)
      PH_MAIN: load_val = dur[DUR_MAIN];
      PH_OUT:  load_val = dur[DUR_OUT];
      PH_RST:  load_val = dur[DUR_RST];
      default: load_val = dur[DUR_DET];
    endcase
  end

  assign load = start || (adv && (phase_d != PH_IDLE));

  always_ff @(posedge clk) begin
    if (rst) phase_q <= PH_IDLE;
    else     phase_q <= phase_d;
  end

  dps_phase_timer #(.CNT_W(CNT_W)) u_timer (
    .clk(clk), .rst(rst), .load(load), .count(load_val), .last(last)
  );

  dps_path_select u_sel (
    .clk(clk), .rst(rst), .clear(start),
    .det_active(phase_q == PH_DET),
    .commit((phase_q == PH_DET) && last),
    .cmp_hit(cmp_hit), .sel_q(sel_q), .sel_d(sel_d)
  );

  function automatic sw_t decode(phase_e p, logic s);
    sw_t o;
    o = '0;
    unique case (p)
      PH_DET:        o.lo = 1'b1;
      PH_MAIN,
      PH_OUT: begin
        o.hi = s;
        o.lo = !s;
        o.fb = !s;
      end
      PH_RST:        o.nrst = 1'b1;
      default:       o = '0;
    endcase
    return o;
  endfunction

  assign sw_d = decode(phase_d, sel_d);

  always_ff @(posedge clk) begin
    if (rst) begin
      sw_q   <= '0;
      flag_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      sw_q   <= sw_d;
      done_q <= (phase_q == PH_OUT) && last;
      if (start) begin
        flag_q <= 1'b0;
      end else if ((phase_q == PH_MAIN) && (phase_d == PH_OUT)) begin
        flag_q <= sel_q;
      end
    end
  end

  assign sw_hi     = sw_q.hi;
  assign sw_lo     = sw_q.lo;
  assign fb_cap_en = sw_q.fb;
  assign sw_rst    = sw_q.nrst;
  assign path_flag = flag_q;
  assign done      = done_q;

endmodule

// File: rtl/dps_checker.sv
module dps_checker (
  input logic clk,
  input logic rst,
  input logic sw_hi,
  input logic sw_lo,
  input logic fb_cap_en,
  input logic sw_rst,
  input logic path_flag,
  input logic done
);

  p_paths_exclusive_r7: assert property (@(posedge clk) disable iff (rst)
    !(sw_hi && sw_lo));

  p_reset_alone_r8: assert property (@(posedge clk) disable iff (rst)
    sw_rst |-> (!sw_hi && !sw_lo && !fb_cap_en));

  p_fb_with_lo_r6: assert property (@(posedge clk) disable iff (rst)
    fb_cap_en |-> (sw_lo && !sw_hi));

  p_hi_held_r5: assert property (@(posedge clk) disable iff (rst)
    sw_hi |=> (sw_hi || sw_rst));

  p_done_single_r10: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  p_done_in_reset_r10: assert property (@(posedge clk) disable iff (rst)
    done |-> sw_rst);

  p_flag_stable_r9: assert property (@(posedge clk) disable iff (rst)
    sw_rst |=> $stable(path_flag));

endmodule

bind dual_path_frame_seq dps_checker u_dps_chk (
  .clk(clk), .rst(rst), .sw_hi(sw_hi), .sw_lo(sw_lo),
  .fb_cap_en(fb_cap_en), .sw_rst(sw_rst), .path_flag(path_flag),
  .done(done)
);

// File: tb/dual_path_frame_seq_bench.sv
module dual_path_frame_seq_bench;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_addr = '0;
  logic [15:0] cfg_wdata = '0;
  logic        frame_go = 1'b0;
  logic        cmp_hit = 1'b0;
  logic        sw_hi, sw_lo, fb_cap_en, sw_rst, path_flag, done;

  int errors = 0;
  int checks = 0;
  int cycles = 0;

  always #10 clk = ~clk;

  dual_path_frame_seq u_dual_path_frame_seq (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .frame_go(frame_go), .cmp_hit(cmp_hit),
    .sw_hi(sw_hi), .sw_lo(sw_lo), .fb_cap_en(fb_cap_en), .sw_rst(sw_rst),
    .path_flag(path_flag), .done(done)
  );

  typedef struct packed {
    logic [15:0] d;
    logic [15:0] m;
    logic [15:0] o;
    logic [15:0] r;
    logic [7:0]  cmp_at;
    logic        cmp_main;
    logic        cmp_pre;
  } vec_t;

  localparam int NV = 7;
  localparam vec_t VECS [NV] = '{
    '{16'd3, 16'd5, 16'd2, 16'd2, 8'd0, 1'b0, 1'b0},
    '{16'd3, 16'd5, 16'd2, 16'd2, 8'd2, 1'b0, 1'b0},
    '{16'd4, 16'd3, 16'd1, 16'd1, 8'd4, 1'b0, 1'b0},
    '{16'd2, 16'd4, 16'd2, 16'd2, 8'd0, 1'b1, 1'b0},
    '{16'd0, 16'd0, 16'd0, 16'd0, 8'd1, 1'b0, 1'b0},
    '{16'd1, 16'd2, 16'd1, 16'd3, 8'd0, 1'b0, 1'b1},
    '{16'd5, 16'd2, 16'd3, 16'd1, 8'd1, 1'b0, 1'b0}
  };

  task automatic check(input logic ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic write_cfg(input logic [1:0] a, input logic [15:0] v);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = v;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  function automatic int eff(input logic [15:0] v);
    return (v == 16'd0) ? 1 : int'(v);
  endfunction

  // switch vector {sw_hi, sw_lo, fb_cap_en, sw_rst}
  task automatic run_frame(input vec_t v);
    int D, M, O, Rr, total;
    logic sel;
    logic [3:0] exp_sw, act_sw;
    string tag;
    D = eff(v.d); M = eff(v.m); O = eff(v.o); Rr = eff(v.r);
    total = D + M + O + Rr;
    sel = (v.cmp_at != 8'd0) && (int'(v.cmp_at) <= D);
    @(negedge clk);
    frame_go = 1'b1; cmp_hit = v.cmp_pre;
    @(negedge clk);
    frame_go = 1'b0; cmp_hit = 1'b0;
    for (int t = 0; t < total; t++) begin
      act_sw = {sw_hi, sw_lo, fb_cap_en, sw_rst};
      if (t < D) begin
        exp_sw = 4'b0100; tag = "R4 detect switches";
      end else if (t < D + M) begin
        exp_sw = sel ? 4'b1000 : 4'b0110;
        tag = sel ? "R5 main high path" : "R6 main low path";
      end else if (t < D + M + O) begin
        exp_sw = sel ? 4'b1000 : 4'b0110; tag = "R7 output holds path";
      end else begin
        exp_sw = 4'b0001; tag = "R8 reset switch";
      end
      check(act_sw == exp_sw, $sformatf("%s t=%0d (R2 R3 timing)", tag, t),
            int'(act_sw), int'(exp_sw));
      check(path_flag == ((t >= D + M) ? sel : 1'b0),
            $sformatf("R9 flag t=%0d", t), int'(path_flag),
            int'((t >= D + M) ? sel : 1'b0));
      check(done == (t == D + M + O), $sformatf("R10 done t=%0d", t),
            int'(done), int'(t == D + M + O));
      // R11: a start request and late comparator hits are injected mid-frame
      cmp_hit  = ((t + 1) == int'(v.cmp_at)) || (v.cmp_main && t == D);
      frame_go = (t == D);
      @(negedge clk);
    end
    cmp_hit = 1'b0; frame_go = 1'b0;
    for (int k = 0; k < 2; k++) begin
      act_sw = {sw_hi, sw_lo, fb_cap_en, sw_rst};
      check(act_sw == 4'b0000 && !done, "R8 R11 idle after frame",
            int'({act_sw, done}), 0);
      check(path_flag == sel, "R9 flag held in idle", int'(path_flag), int'(sel));
      @(negedge clk);
    end
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 20000) begin
        errors++;
        checks++;
        $display("FAIL watchdog: actual=%0d expected<=20000", cycles);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check({sw_hi, sw_lo, fb_cap_en, sw_rst, path_flag, done} == 6'b0,
          "R1 reset state", int'({sw_hi, sw_lo, fb_cap_en, sw_rst, path_flag, done}), 0);

    // R1: default counts 4/8/2/2 after reset, no writes
    run_frame('{16'd4, 16'd8, 16'd2, 16'd2, 8'd3, 1'b0, 1'b0});

    for (int i = 0; i < NV; i++) begin
      write_cfg(2'd0, VECS[i].d);
      write_cfg(2'd1, VECS[i].m);
      write_cfg(2'd2, VECS[i].o);
      write_cfg(2'd3, VECS[i].r);
      run_frame(VECS[i]);
    end

    // R1: reset in the middle of a high-path frame
    write_cfg(2'd0, 16'd2);
    write_cfg(2'd1, 16'd9);
    @(negedge clk);
    frame_go = 1'b1;
    @(negedge clk);
    frame_go = 1'b0; cmp_hit = 1'b1;
    @(negedge clk);
    cmp_hit = 1'b0;
    repeat (5) @(negedge clk);
    check(sw_hi == 1'b1, "R5 high path before mid-frame reset", int'(sw_hi), 1);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check({sw_hi, sw_lo, fb_cap_en, sw_rst, path_flag, done} == 6'b0,
          "R1 mid-frame reset clears outputs",
          int'({sw_hi, sw_lo, fb_cap_en, sw_rst, path_flag, done}), 0);
    run_frame('{16'd4, 16'd8, 16'd2, 16'd2, 8'd0, 1'b0, 1'b0});

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule